// File: doc/BRIEF.md
# Event Counter Bank with Register Access

This block holds a set of general-purpose event counters and one wide free-running cycle counter. A plain 32-bit register port reaches all of them. A memory controller, or any other source, supplies a 64-bit vector of single-cycle event strobes.

Software assigns each general counter one line of that vector and sets its enable bit. It then starts and stops the whole bank through a control register. Software can also force a chosen value into any one counter through an indirect preload path.

Each general counter drives its own wrap pulse to an external interrupt block. The counter values, the event-select words and the cycle counter are all read back over the register port.

The register port accepts a read or a write in every cycle and never applies back-pressure. Each read returns its data one cycle later, qualified by a valid strobe. The event vector and the wrap pulses are plain strobes with no handshake.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every general counter, the cycle counter, the cycle low shadow, every event-select word and the test-select word read as zero, and the bank is stopped.
- R2: The event-select words sit at byte offset 0xC68 + 4*k. Counter n is configured by the word at 0xC68 + 4*(n/4), in the 8-bit lane at bit 8*(n%4). Within a lane, bit 7 enables the counter and bits 5:0 give its event line. Bit 6 is stored and read back but has no function.
- R3: While the bank runs, an enabled counter adds exactly one in each clock cycle where its selected event line is high.
- R4: A counter holds its value while the bank is stopped or its enable bit is clear. Strobes on event lines other than the selected one never change it.
- R5: The control word at 0xC00 reads as zero. Writing bit 0 starts the bank and writing bit 1 stops it; if both are set, stop wins. Writing bit 2 clears all general counters and the cycle counter to zero.
- R6: General counter n reads at 0xC78 + 4*n. Writes to these addresses are ignored.
- R7: When the test-select word at 0xC08 holds 19+n, a write to the preload address 0xC0C loads the written value into counter n. While the test-select word holds any other value, preload writes change no counter.
- R8: When a preload and a counted event reach the same counter in the same cycle, the counter takes the preload value.
- R9: General counters wrap modulo 2^32. An increment from 0xFFFFFFFF to 0 raises that counter's bit of wrap_pulse for exactly one cycle, in the same cycle the counter first holds 0. A preload or a clear never raises wrap_pulse.
- R10: The 56-bit cycle counter adds one each clock while the bank runs. A read of 0xC10 returns its bits 55:32, zero-extended, and in the same cycle copies bits 31:0 into a shadow. A read of 0xC14 returns that shadow.
- R11: A read asserts bus_rvalid with bus_rdata in the following cycle only. Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, accepted in the same cycle |
| bus_rd | input | 1 | Read strobe, accepted in the same cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after an accepted read |
| event_in | input | 64 | Single-cycle event strobes, one line per event number |
| wrap_pulse | output | 16 | One-cycle pulse per counter on rollover |

## Verification
A table of vectors drives counters in every lane position and every select word, including event lines 0 and 63. Each vector pairs the selected strobe with a strobe on a neighbouring line. This shows whether lane decoding and event selection are exact, and not merely counting any activity.

Directed sequences then separate the effects of the stopped bank, a cleared enable bit, stop-wins control and the global clear. The same sequences show that preload fires only for an in-range test-select value and beats a coincident event. The wrap pulse appears only on a counted rollover. Reading the cycle counter while it runs, with a gap before the low half, shows whether the low half is the value captured at the high read or a later, torn one.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int LANES     = 4;
  localparam int TSEL_BASE = 19;

  localparam logic [11:0] OFF_CTRL = 12'hC00;
  localparam logic [11:0] OFF_TSEL = 12'hC08;
  localparam logic [11:0] OFF_PRE  = 12'hC0C;
  localparam logic [11:0] OFF_CYH  = 12'hC10;
  localparam logic [11:0] OFF_CYL  = 12'hC14;
  localparam logic [11:0] OFF_SEL0 = 12'hC68;
  localparam logic [11:0] OFF_CNT0 = 12'hC78;

  localparam int CTRL_START = 0;
  localparam int CTRL_STOP  = 1;
  localparam int CTRL_CLEAR = 2;
endpackage

// File: rtl/evcnt_cfg.sv
module evcnt_cfg
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int EV_W    = 64,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr,
  input  logic [AW-1:0]                          addr,
  input  logic [DW-1:0]                          wdata,
  output logic                                   run,
  output logic                                   clr,
  output logic [NUM_CNT/LANES-1:0][DW-1:0]       sel_word,
  output logic [DW-1:0]                          tsel,
  output logic [NUM_CNT-1:0]                     cnt_en,
  output logic [NUM_CNT-1:0][$clog2(EV_W)-1:0]   cnt_ev,
  output logic [NUM_CNT-1:0]                     pl_hit
);
  localparam int SELW   = $clog2(EV_W);
  localparam int NSEL   = NUM_CNT / LANES;
  localparam int LANE_W = DW / LANES;

  logic          wr_ctrl;
  logic          wr_pre;
  logic [DW-1:0] pl_idx;

  assign wr_ctrl = wr && (addr == AW'(OFF_CTRL));
  assign wr_pre  = wr && (addr == AW'(OFF_PRE));
  assign clr     = wr_ctrl && wdata[CTRL_CLEAR];
  assign pl_idx  = tsel - DW'(TSEL_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      tsel <= '0;
    end else begin
      if (wr_ctrl) begin
        if (wdata[CTRL_STOP])       run <= 1'b0;
        else if (wdata[CTRL_START]) run <= 1'b1;
      end
      if (wr && (addr == AW'(OFF_TSEL))) tsel <= wdata;
    end
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)                                      sel_word[k] <= '0;
      else if (wr && (addr == AW'(OFF_SEL0) + AW'(4*k))) sel_word[k] <= wdata;
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_lane
    assign cnt_en[n] = sel_word[n/LANES][LANE_W*(n%LANES) + LANE_W - 1];
    assign cnt_ev[n] = sel_word[n/LANES][LANE_W*(n%LANES) +: SELW];
    assign pl_hit[n] = wr_pre && (pl_idx == DW'(n));
  end

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTRL_STOP]) |=> !run); // R5
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTRL_START] && !wdata[CTRL_STOP]) |=> run); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(run)); // R5
endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell #(
  parameter int CNT_W = 32,
  parameter int EV_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     clr,
  input  logic                     en,
  input  logic [$clog2(EV_W)-1:0]  ev,
  input  logic [EV_W-1:0]          event_in,
  input  logic                     pl,
  input  logic [CNT_W-1:0]         pl_val,
  output logic [CNT_W-1:0]         count,
  output logic                     wrap
);
  logic hit;
  assign hit = run && en && event_in[ev];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
      wrap  <= 1'b0;
    end else if (pl) begin
      count <= pl_val;
      wrap  <= 1'b0;
    end else if (hit) begin
      count <= count + 1'b1;
      wrap  <= &count;
    end else begin
      wrap  <= 1'b0;
    end
  end

  AST_WRAP_ON_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == '0) && ($past(count) == '1) && $past(hit)); // R9
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && !clr) |=> (count == $past(pl_val))); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !pl && !clr) |=> $stable(count)); // R4
endmodule

// File: rtl/evcnt_cycle.sv
module evcnt_cycle #(
  parameter int CYC_W = 56,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             rd_hi,
  output logic [CYC_W-1:0] cyc,
  output logic [DW-1:0]    shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cyc <= '0;
    else if (run)      cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     shadow <= '0;
    else if (rd_hi) shadow <= cyc[DW-1:0];
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (shadow == $past(cyc[DW-1:0]))); // R10
  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cyc)); // R10
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 56,
  parameter int EV_W    = 64,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_rvalid,
  input  logic [EV_W-1:0]    event_in,
  output logic [NUM_CNT-1:0] wrap_pulse
);
  localparam int SELW = $clog2(EV_W);
  localparam int NSEL = NUM_CNT / LANES;

  logic                            run;
  logic                            clr;
  logic [NSEL-1:0][DW-1:0]         sel_word;
  logic [DW-1:0]                   tsel;
  logic [NUM_CNT-1:0]              cnt_en;
  logic [NUM_CNT-1:0][SELW-1:0]    cnt_ev;
  logic [NUM_CNT-1:0]              pl_hit;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt;
  logic [CYC_W-1:0]                cyc;
  logic [DW-1:0]                   shadow;
  logic                            rd_hi;
  logic [DW-1:0]                   rd_mux;

  evcnt_cfg #(.NUM_CNT(NUM_CNT), .EV_W(EV_W), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .run(run), .clr(clr), .sel_word(sel_word), .tsel(tsel),
    .cnt_en(cnt_en), .cnt_ev(cnt_ev), .pl_hit(pl_hit)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    evcnt_cell #(.CNT_W(CNT_W), .EV_W(EV_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
      .en(cnt_en[n]), .ev(cnt_ev[n]), .event_in(event_in),
      .pl(pl_hit[n]), .pl_val(bus_wdata[CNT_W-1:0]),
      .count(cnt[n]), .wrap(wrap_pulse[n])
    );
  end

  assign rd_hi = bus_rd && (bus_addr == AW'(OFF_CYH));

  evcnt_cycle #(.CYC_W(CYC_W), .DW(DW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .rd_hi(rd_hi),
    .cyc(cyc), .shadow(shadow)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFF_TSEL)) rd_mux = tsel;
    if (bus_addr == AW'(OFF_CYH))  rd_mux = DW'(cyc[CYC_W-1:DW]);
    if (bus_addr == AW'(OFF_CYL))  rd_mux = shadow;
    for (int k = 0; k < NSEL; k++)
      if (bus_addr == AW'(OFF_SEL0) + AW'(4*k)) rd_mux = sel_word[k];
    for (int i = 0; i < NUM_CNT; i++)
      if (bus_addr == AW'(OFF_CNT0) + AW'(4*i)) rd_mux = DW'(cnt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R11
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R11
endmodule

// File: tb/evcnt_bank_bench.sv
`timescale 1ns/1ps
module evcnt_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] event_in = '0;
  logic [15:0] wrap_pulse;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evcnt_bank u_evcnt_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .event_in(event_in), .wrap_pulse(wrap_pulse)
  );

  localparam int NV = 6;
  localparam int V_CNT [NV] = '{0, 5, 10, 15, 3, 12};
  localparam int V_EV  [NV] = '{0, 63, 17, 42, 1, 33};
  localparam int V_N   [NV] = '{3, 1, 7, 4, 0, 10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R11 rvalid", {31'b0, bus_rvalid}, 32'd1);
  endtask

  task automatic pulse(input int ev, input int other);
    event_in = '0;
    event_in[ev] = 1'b1;
    if (other >= 0) event_in[other] = 1'b1;
    @(negedge clk);
    event_in = '0;
  endtask

  function automatic logic [11:0] sel_addr(input int n);
    return 12'hC68 + 12'(4 * (n / 4));
  endfunction

  function automatic logic [11:0] cnt_addr(input int n);
    return 12'hC78 + 12'(4 * n);
  endfunction

  function automatic logic [31:0] lane(input int n, input int ev, input bit en);
    return {24'b0, en, 1'b0, 6'(ev)} << (8 * (n % 4));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(cnt_addr(0), d);  chk("R1 counter0", d, 0);
    rd(cnt_addr(15), d); chk("R1 counter15", d, 0);
    rd(12'hC10, d);      chk("R1 cycle high", d, 0);
    rd(12'hC14, d);      chk("R1 cycle low", d, 0);
    rd(12'hC68, d);      chk("R1 select0", d, 0);
    rd(12'hC08, d);      chk("R1 test select", d, 0);
    @(negedge clk);
    chk("R11 rvalid idle", {31'b0, bus_rvalid}, 0);

    // table walk: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 4; k++) wr(12'hC68 + 12'(4 * k), 0);
      wr(sel_addr(V_CNT[v]), lane(V_CNT[v], V_EV[v], 1'b1));
      wr(12'hC00, 32'h4);
      wr(12'hC00, 32'h1);
      for (int p = 0; p < V_N[v]; p++) pulse(V_EV[v], V_EV[v] ^ 1);
      pulse(V_EV[v] ^ 2, -1);
      wr(12'hC00, 32'h2);
      rd(cnt_addr(V_CNT[v]), d);
      chk($sformatf("R3 vector %0d count", v), d, V_N[v]);
      rd(cnt_addr(V_CNT[v] ^ 1), d);
      chk($sformatf("R4 vector %0d neighbour", v), d, 0);
      rd(sel_addr(V_CNT[v]), d);
      chk($sformatf("R2 vector %0d select readback", v), d, lane(V_CNT[v], V_EV[v], 1'b1));
    end

    // R2 bit 6 stored, R5 control reads zero, R11 unmapped
    wr(12'hC6C, 32'h40C0_4000);
    rd(12'hC6C, d); chk("R2 reserved bit readback", d, 32'h40C0_4000);
    rd(12'hC00, d); chk("R5 control reads zero", d, 0);
    rd(12'h004, d); chk("R11 unmapped", d, 0);

    // R4 stopped bank holds
    for (int k = 0; k < 4; k++) wr(12'hC68 + 12'(4 * k), 0);
    wr(12'hC00, 32'h4);
    wr(sel_addr(2), lane(2, 5, 1'b1));
    pulse(5, -1);
    rd(cnt_addr(2), d); chk("R4 stopped no count", d, 0);
    wr(12'hC00, 32'h1);
    pulse(5, -1); pulse(5, -1);
    rd(cnt_addr(2), d); chk("R3 running count", d, 2);
    wr(12'hC00, 32'h2);
    pulse(5, -1);
    rd(cnt_addr(2), d); chk("R4 stop holds", d, 2);
    // R4 disabled lane while running
    wr(sel_addr(2), lane(2, 5, 1'b0));
    wr(12'hC00, 32'h1);
    pulse(5, -1);
    rd(cnt_addr(2), d); chk("R4 disabled holds", d, 2);
    // R5 stop wins over start
    wr(sel_addr(2), lane(2, 5, 1'b1));
    wr(12'hC00, 32'h3);
    pulse(5, -1);
    rd(cnt_addr(2), d); chk("R5 stop wins", d, 2);
    // R6 write to counter ignored
    wr(cnt_addr(2), 32'h5555_0000);
    rd(cnt_addr(2), d); chk("R6 write ignored", d, 2);
    // R5 clear
    wr(12'hC00, 32'h4);
    rd(cnt_addr(2), d); chk("R5 clear", d, 0);

    // R7 preload
    wr(12'hC08, 19 + 7);
    wr(12'hC0C, 32'h1234_5678);
    rd(cnt_addr(7), d); chk("R7 preload loads", d, 32'h1234_5678);
    rd(cnt_addr(6), d); chk("R7 preload other untouched", d, 0);
    wr(12'hC08, 0);
    wr(12'hC0C, 32'hDEAD);
    rd(cnt_addr(7), d); chk("R7 deselected preload ignored", d, 32'h1234_5678);
    rd(cnt_addr(0), d); chk("R7 deselected counter0", d, 0);
    wr(12'hC08, 19 + 16);
    wr(12'hC0C, 32'hBEEF);
    rd(cnt_addr(15), d); chk("R7 out of range ignored", d, 0);

    // R8 preload beats event
    wr(sel_addr(7), lane(7, 9, 1'b1));
    wr(12'hC00, 32'h1);
    wr(12'hC08, 19 + 7);
    bus_wr = 1'b1; bus_addr = 12'hC0C; bus_wdata = 32'h100; event_in[9] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; event_in = '0;
    rd(cnt_addr(7), d); chk("R8 preload wins", d, 32'h100);
    pulse(9, -1);
    rd(cnt_addr(7), d); chk("R8 counts after preload", d, 32'h101);

    // R9 wrap pulse
    wr(12'hC0C, 32'hFFFF_FFFF);
    chk("R9 no pulse on preload", {16'b0, wrap_pulse}, 0);
    pulse(9, -1);
    chk("R9 wrap pulse", {16'b0, wrap_pulse}, 32'h0080);
    @(negedge clk);
    chk("R9 pulse one cycle", {16'b0, wrap_pulse}, 0);
    rd(cnt_addr(7), d); chk("R9 wrapped to zero", d, 0);
    wr(12'hC00, 32'h2);

    // R10 cycle counter coherent read
    wr(12'hC00, 32'h4);
    wr(12'hC00, 32'h1);
    repeat (9) @(negedge clk);
    rd(12'hC10, d); chk("R10 high half", d, 0);
    repeat (4) @(negedge clk);
    rd(12'hC14, d); chk("R10 low from shadow", d, 9);
    rd(12'hC10, d); chk("R10 high again", d, 0);
    rd(12'hC14, d); chk("R10 low recaptured", d, 15);

    finish_run();
  end
endmodule